// File: doc/BRIEF.md
# Transactional Two-Way Cache with Overflow Spill

This block is a two-way set-associative data cache that records which lines a transaction has touched. Each line has a transactional mark and each set has a spill flag. A transactional line that loses a replacement is not written to lower memory. It moves into a small spill table. A later miss in a flagged set scans that table and swaps the line back into the set, as a victim cache would. The whole transactional footprint is either discarded at once (abort) or made permanent (commit). Commit writes the spill table out to lower memory, and during that writeback external interventions are refused.

The core issues one request at a time: loads, stores and the begin, commit and abort pulses. It may issue only while `ready` is high. Each access ends with a one-cycle `resp_valid` pulse. Lower memory uses a simple request/acknowledge port: `mem_req` is held until `mem_ack` arrives.

The controller is a single state machine with these states:
- `S_IDLE`: accepts work.
- `S_CHECK`: tag compare and access.
- `S_CLEAN`: writes back a dirty unmarked line before a transaction touches it.
- `S_SCAN`: searches the spill table.
- `S_EVICT`: victim decision, spill or swap.
- `S_WB`: dirty writeback of an unmarked victim.
- `S_SWAPIN`: restores a table entry into the set.
- `S_FILL`: reads the line from lower memory.
- `S_CMT`: drains the spill table.

The transitions are:
- IDLE→CHECK on a request, and IDLE→CMT on commit. Begin and abort complete inside IDLE.
- CHECK→IDLE on a completed hit, CHECK→CLEAN on a dirty unmarked hit inside a transaction, CHECK→SCAN on a miss in a flagged set, and CHECK→EVICT on a miss in an unflagged set.
- CLEAN→CHECK on acknowledge.
- SCAN→EVICT on a match or after the last entry.
- EVICT→CHECK on an in-place swap, EVICT→FILL after a spill or a clean victim, EVICT→WB on a dirty unmarked victim, and EVICT→SWAPIN on a table match with an unmarked victim.
- WB→SWAPIN or WB→FILL on acknowledge.
- SWAPIN→CHECK.
- FILL→CHECK on acknowledge.
- CMT→IDLE after the last table entry.

Top module: `tx_spill_cache`

## Requirements
- R1: After reset `ready` is 1, and `tx_active`, `ovf_err`, `nack`, `mem_req` and `resp_valid` are 0.
- R2: A load returns the latest value stored to its address, and a store's response echoes the stored data. The set index is the low log2(SETS) address bits. `mem_req` and `mem_addr` stay unchanged until `mem_ack`.
- R3: A load or store made while a transaction is open marks the accessed line as transactional, so an abort discards every store made in that transaction.
- R4: The replacement victim is an invalid way if the set has one, otherwise the least recently used way.
- R5: An unmarked victim is evicted normally. It is written to lower memory only if dirty, and a clean one causes no write.
- R6: A marked victim is moved into the spill table and the set's spill flag is set. No lower-memory write occurs.
- R7: A miss in a flagged set scans the spill table one entry per cycle. On a match the line is swapped back with no lower-memory read. Without a match the miss proceeds to lower memory.
- R8: The table holds OVF_DEPTH (8) entries. Spilling into a full table raises `ovf_err`, which stays set until commit or abort.
- R9: Abort invalidates every marked line, empties the table, clears all marks and flags, clears `ovf_err` and `tx_active`, and takes one cycle.
- R10: Commit writes each valid table entry to lower memory, clears all marks and flags, and closes the transaction. Committed data remains readable afterwards.
- R11: `nack` is high only when `ext_intv` is high during the commit writeback, and never at any other time.
- R12: Inside a transaction, a dirty unmarked line is first written back to lower memory before it is accessed and marked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Core access request (taken when ready) |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Store data |
| ready | output | 1 | Controller idle, accepts request or control pulse |
| resp_valid | output | 1 | One-cycle access completion |
| resp_rdata | output | DW | Load data, or echoed store data |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the transaction |
| tx_abort | input | 1 | Abort the transaction |
| tx_active | output | 1 | Transaction open |
| ovf_err | output | 1 | Spill attempted into a full table |
| mem_req | output | 1 | Lower-memory request, held until ack |
| mem_we | output | 1 | Lower-memory write |
| mem_addr | output | AW | Lower-memory address |
| mem_wdata | output | DW | Lower-memory write data |
| mem_ack | input | 1 | Lower-memory acknowledge |
| mem_rdata | input | DW | Lower-memory read data (valid with ack) |
| ext_intv | input | 1 | External intervention request |
| nack | output | 1 | Intervention refused |

## Verification
Plain non-transactional traffic into one set separates true LRU selection from a fixed way choice, and separates dirty writeback from silent clean eviction. Three transactional stores into one set followed by a reload of the first one show whether a marked victim is spilled rather than written, and whether it returns from the table rather than from memory. A commit that follows shows whether exactly the table contents reach memory while interventions are refused. Ten and then eleven marked lines in one set locate the exact table-full boundary. A store to a dirty line just before an abort shows whether the pre-transaction value survives.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CHECK,
        S_CLEAN,
        S_SCAN,
        S_EVICT,
        S_WB,
        S_SWAPIN,
        S_FILL,
        S_CMT
    } tc_state_e;

endpackage

// File: rtl/tcache_lru.sv
module tcache_lru #(
    parameter int SETS = 4,
    parameter int IW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            touch,
    input  logic [IW-1:0]   touch_set,
    input  logic            touch_way,
    output logic [SETS-1:0] lru_way
);

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lru_way[s] <= 1'b0;
            end else if (touch && touch_set == IW'(s)) begin
                lru_way[s] <= ~touch_way;
            end
        end
    end

    // R4
    lru_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> (lru_way[$past(touch_set)] != $past(touch_way)));

endmodule

// File: rtl/tcache_ovf_tbl.sv
module tcache_ovf_tbl #(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int DEPTH = 8,
    parameter int OW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [OW-1:0] wr_idx,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_dirty,
    input  logic          inv_en,
    input  logic [OW-1:0] inv_idx,
    input  logic [OW-1:0] rd_idx,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          rd_dirty,
    output logic          free_found,
    output logic [OW-1:0] free_idx
);

    logic [DEPTH-1:0] ent_v;
    logic [DEPTH-1:0] ent_d;
    logic [AW-1:0]    ent_a [DEPTH];
    logic [DW-1:0]    ent_x [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_v[e] <= 1'b0;
                ent_d[e] <= 1'b0;
            end else if (clear) begin
                ent_v[e] <= 1'b0;
            end else if (wr_en && wr_idx == OW'(e)) begin
                ent_v[e] <= 1'b1;
                ent_d[e] <= wr_dirty;
            end else if (inv_en && inv_idx == OW'(e)) begin
                ent_v[e] <= 1'b0;
            end
        end

        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == OW'(e)) begin
                ent_a[e] <= wr_addr;
                ent_x[e] <= wr_data;
            end
        end
    end

    assign rd_valid = ent_v[rd_idx];
    assign rd_addr  = ent_a[rd_idx];
    assign rd_data  = ent_x[rd_idx];
    assign rd_dirty = ent_d[rd_idx];

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int e = DEPTH - 1; e >= 0; e--) begin
            if (!ent_v[e]) begin
                free_found = 1'b1;
                free_idx   = OW'(e);
            end
        end
    end

    // R9
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (ent_v == '0));

endmodule

// File: rtl/tx_spill_cache.sv
module tx_spill_cache
    import tcache_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 16,
    parameter int SETS      = 4,
    parameter int OVF_DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          resp_valid,
    output logic [DW-1:0] resp_rdata,
    input  logic          tx_begin,
    input  logic          tx_commit,
    input  logic          tx_abort,
    output logic          tx_active,
    output logic          ovf_err,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata,
    input  logic          ext_intv,
    output logic          nack
);

    localparam int WAYS = 2;
    localparam int IW   = $clog2(SETS);
    localparam int TW   = AW - IW;
    localparam int OW   = $clog2(OVF_DEPTH);
    localparam logic [OW-1:0] LAST = OW'(OVF_DEPTH - 1);

    tc_state_e state, nxt;

    // line arrays
    logic          lv   [WAYS][SETS];
    logic          ld   [WAYS][SETS];
    logic          lt   [WAYS][SETS];
    logic [TW-1:0] ltag [WAYS][SETS];
    logic [DW-1:0] ldat [WAYS][SETS];
    logic [SETS-1:0] oflag;

    // latched request
    logic          r_we;
    logic [AW-1:0] r_addr;
    logic [DW-1:0] r_wdata;
    logic [IW-1:0] r_set;
    logic [TW-1:0] r_tag;
    assign r_set = r_addr[IW-1:0];
    assign r_tag = r_addr[AW-1:IW];

    // lookup
    logic hit0, hit1, hit, hway, need_clean;
    assign hit0 = lv[0][r_set] && ltag[0][r_set] == r_tag;
    assign hit1 = lv[1][r_set] && ltag[1][r_set] == r_tag;
    assign hit  = hit0 || hit1;
    assign hway = hit1;
    assign need_clean = tx_active && ld[hway][r_set] && !lt[hway][r_set];

    // victim
    logic [SETS-1:0] lru_way;
    logic vway_c, vic_way, vvalid, vt, vdirty;
    assign vway_c = !lv[0][r_set] ? 1'b0 : (!lv[1][r_set] ? 1'b1 : lru_way[r_set]);
    assign vvalid = lv[vway_c][r_set];
    assign vt     = lt[vway_c][r_set];
    assign vdirty = ld[vway_c][r_set];

    // spill table
    logic          found;
    logic [OW-1:0] scan_idx;
    logic          tb_rd_valid, tb_rd_dirty, tb_free_found;
    logic [AW-1:0] tb_rd_addr;
    logic [DW-1:0] tb_rd_data;
    logic [OW-1:0] tb_free_idx;
    logic          tb_wr_en, tb_inv_en, tb_clear, match;

    assign match     = tb_rd_valid && tb_rd_addr == r_addr;
    assign tb_clear  = state == S_IDLE && tx_abort;
    assign tb_wr_en  = state == S_EVICT && vvalid && vt && (found || tb_free_found);
    assign tb_inv_en = (state == S_SWAPIN) || (state == S_CMT && tb_rd_valid && mem_ack);

    tcache_ovf_tbl #(.AW(AW), .DW(DW), .DEPTH(OVF_DEPTH), .OW(OW)) u_tbl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (tb_clear),
        .wr_en      (tb_wr_en),
        .wr_idx     (found ? scan_idx : tb_free_idx),
        .wr_addr    ({ltag[vway_c][r_set], r_set}),
        .wr_data    (ldat[vway_c][r_set]),
        .wr_dirty   (vdirty),
        .inv_en     (tb_inv_en),
        .inv_idx    (scan_idx),
        .rd_idx     (scan_idx),
        .rd_valid   (tb_rd_valid),
        .rd_addr    (tb_rd_addr),
        .rd_data    (tb_rd_data),
        .rd_dirty   (tb_rd_dirty),
        .free_found (tb_free_found),
        .free_idx   (tb_free_idx)
    );

    logic lru_touch;
    assign lru_touch = state == S_CHECK && hit && !need_clean;

    tcache_lru #(.SETS(SETS), .IW(IW)) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch     (lru_touch),
        .touch_set (r_set),
        .touch_way (hway),
        .lru_way   (lru_way)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (tx_abort)       nxt = S_IDLE;
                else if (tx_commit) nxt = S_CMT;
                else if (tx_begin)  nxt = S_IDLE;
                else if (req_valid) nxt = S_CHECK;
            end
            S_CHECK: begin
                if (hit)               nxt = need_clean ? S_CLEAN : S_IDLE;
                else if (oflag[r_set]) nxt = S_SCAN;
                else                   nxt = S_EVICT;
            end
            S_CLEAN:  if (mem_ack) nxt = S_CHECK;
            S_SCAN:   if (match || scan_idx == LAST) nxt = S_EVICT;
            S_EVICT: begin
                if (vvalid && vt)          nxt = found ? S_CHECK : S_FILL;
                else if (vvalid && vdirty) nxt = S_WB;
                else                       nxt = found ? S_SWAPIN : S_FILL;
            end
            S_WB:     if (mem_ack) nxt = found ? S_SWAPIN : S_FILL;
            S_SWAPIN: nxt = S_CHECK;
            S_FILL:   if (mem_ack) nxt = S_CHECK;
            S_CMT:    if (scan_idx == LAST && (!tb_rd_valid || mem_ack)) nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready     = state == S_IDLE;
        nack      = ext_intv && state == S_CMT;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = r_addr;
        mem_wdata = ldat[hway][r_set];
        unique case (state)
            S_CLEAN: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {ltag[vic_way][r_set], r_set};
                mem_wdata = ldat[vic_way][r_set];
            end
            S_FILL: mem_req = 1'b1;
            S_CMT: begin
                mem_req   = tb_rd_valid;
                mem_we    = 1'b1;
                mem_addr  = tb_rd_addr;
                mem_wdata = tb_rd_data;
            end
            default: ;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int w = 0; w < WAYS; w++) begin
                for (int s = 0; s < SETS; s++) begin
                    lv[w][s] <= 1'b0;
                    ld[w][s] <= 1'b0;
                    lt[w][s] <= 1'b0;
                end
            end
            oflag      <= '0;
            r_we       <= 1'b0;
            r_addr     <= '0;
            r_wdata    <= '0;
            resp_valid <= 1'b0;
            resp_rdata <= '0;
            tx_active  <= 1'b0;
            ovf_err    <= 1'b0;
            found      <= 1'b0;
            scan_idx   <= '0;
            vic_way    <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (tx_abort) begin
                        for (int w = 0; w < WAYS; w++) begin
                            for (int s = 0; s < SETS; s++) begin
                                if (lt[w][s]) begin
                                    lv[w][s] <= 1'b0;
                                    lt[w][s] <= 1'b0;
                                end
                            end
                        end
                        oflag     <= '0;
                        ovf_err   <= 1'b0;
                        tx_active <= 1'b0;
                    end else if (tx_commit) begin
                        scan_idx <= '0;
                    end else if (tx_begin) begin
                        tx_active <= 1'b1;
                    end else if (req_valid) begin
                        r_we    <= req_we;
                        r_addr  <= req_addr;
                        r_wdata <= req_wdata;
                    end
                end
                S_CHECK: begin
                    found    <= 1'b0;
                    scan_idx <= '0;
                    if (hit && !need_clean) begin
                        if (r_we) begin
                            ldat[hway][r_set] <= r_wdata;
                            ld[hway][r_set]   <= 1'b1;
                        end
                        if (tx_active) lt[hway][r_set] <= 1'b1;
                        resp_valid <= 1'b1;
                        resp_rdata <= r_we ? r_wdata : ldat[hway][r_set];
                    end
                end
                S_CLEAN: if (mem_ack) ld[hway][r_set] <= 1'b0;
                S_SCAN: begin
                    if (match)                 found    <= 1'b1;
                    else if (scan_idx != LAST) scan_idx <= scan_idx + 1'b1;
                end
                S_EVICT: begin
                    vic_way <= vway_c;
                    if (vvalid && vt) begin
                        oflag[r_set] <= 1'b1;
                        if (found) begin
                            ltag[vway_c][r_set] <= tb_rd_addr[AW-1:IW];
                            ldat[vway_c][r_set] <= tb_rd_data;
                            ld[vway_c][r_set]   <= tb_rd_dirty;
                            lt[vway_c][r_set]   <= 1'b1;
                        end else begin
                            lv[vway_c][r_set] <= 1'b0;
                            lt[vway_c][r_set] <= 1'b0;
                            if (!tb_free_found) ovf_err <= 1'b1;
                        end
                    end
                end
                S_WB: if (mem_ack) ld[vic_way][r_set] <= 1'b0;
                S_SWAPIN: begin
                    lv[vic_way][r_set]   <= 1'b1;
                    lt[vic_way][r_set]   <= 1'b1;
                    ld[vic_way][r_set]   <= tb_rd_dirty;
                    ltag[vic_way][r_set] <= tb_rd_addr[AW-1:IW];
                    ldat[vic_way][r_set] <= tb_rd_data;
                end
                S_FILL: begin
                    if (mem_ack) begin
                        lv[vic_way][r_set]   <= 1'b1;
                        ld[vic_way][r_set]   <= 1'b0;
                        lt[vic_way][r_set]   <= 1'b0;
                        ltag[vic_way][r_set] <= r_tag;
                        ldat[vic_way][r_set] <= mem_rdata;
                    end
                end
                S_CMT: begin
                    if (!tb_rd_valid || mem_ack) scan_idx <= scan_idx + 1'b1;
                    if (scan_idx == LAST && (!tb_rd_valid || mem_ack)) begin
                        for (int w = 0; w < WAYS; w++) begin
                            for (int s = 0; s < SETS; s++) lt[w][s] <= 1'b0;
                        end
                        oflag     <= '0;
                        ovf_err   <= 1'b0;
                        tx_active <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    // R11
    nack_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nack |-> !ready);

    // R2
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8
    spill_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EVICT && vvalid && vt && !found && !tb_free_found) |=> ovf_err);

    // R2
    resp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

// File: tb/tb_tx_spill_cache.sv
module tb_tx_spill_cache;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ready, resp_valid;
    logic [15:0] resp_rdata;
    logic        tx_begin = 1'b0, tx_commit = 1'b0, tx_abort = 1'b0;
    logic        tx_active, ovf_err;
    logic        mem_req, mem_we, mem_ack;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic        ext_intv = 1'b0;
    logic        nack;

    always #4 clk = ~clk;

    tx_spill_cache dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .ready(ready), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
        .tx_begin(tx_begin), .tx_commit(tx_commit), .tx_abort(tx_abort),
        .tx_active(tx_active), .ovf_err(ovf_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .ext_intv(ext_intv), .nack(nack)
    );

    int n_cmp = 0, n_bad = 0;
    int wr_cnt, rd_cnt;
    logic [7:0]  last_wr_addr;
    logic [15:0] last_wr_data;
    logic [15:0] mem     [256];
    logic [15:0] ref_mem [256];
    logic [15:0] spec_val[256];
    bit          spec_has[256];
    bit          in_tx = 1'b0;
    bit          commit_window = 1'b0;
    bit          nack_seen = 1'b0;

    function automatic logic [15:0] init_val(input int a);
        return {8'(a), 8'(a) ^ 8'hA5};
    endfunction

    // lower memory: one-cycle acknowledge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            wr_cnt <= 0;
            rd_cnt <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr];
                if (mem_we) begin
                    mem[mem_addr] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                    last_wr_addr <= mem_addr;
                    last_wr_data <= mem_wdata;
                end else begin
                    rd_cnt <= rd_cnt + 1;
                end
            end
        end
    end

    task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // per-clock comparison of the intervention answer (R11)
    always @(negedge clk) begin
        if (rst_n) begin
            check_eq("R11 nack", {31'd0, nack}, {31'd0, nack & ext_intv & commit_window});
            if (nack) nack_seen = 1'b1;
        end
    end

    task automatic access(input bit we, input logic [7:0] a, input logic [15:0] d,
                          output logic [15:0] rd);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        while (!resp_valid) @(negedge clk);
        rd = resp_rdata;
        if (we) begin
            if (in_tx) begin spec_has[a] = 1'b1; spec_val[a] = d; end
            else ref_mem[a] = d;
        end
    endtask

    task automatic load(input string req, input logic [7:0] a);
        logic [15:0] exp, rd;
        exp = spec_has[a] ? spec_val[a] : ref_mem[a];
        access(1'b0, a, '0, rd);
        check_eq(req, {16'd0, rd}, {16'd0, exp});
    endtask

    task automatic store(input string req, input logic [7:0] a, input logic [15:0] d);
        logic [15:0] rd;
        access(1'b1, a, d, rd);
        check_eq(req, {16'd0, rd}, {16'd0, d});
    endtask

    // 0 begin, 1 commit, 2 abort
    task automatic ctl(input int which);
        @(negedge clk);
        while (!ready) @(negedge clk);
        if (which == 1) commit_window = 1'b1;
        tx_begin  = (which == 0);
        tx_commit = (which == 1);
        tx_abort  = (which == 2);
        @(negedge clk);
        tx_begin = 1'b0; tx_commit = 1'b0; tx_abort = 1'b0;
        while (!ready) @(negedge clk);
        commit_window = 1'b0;
        if (which == 0) in_tx = 1'b1;
        else begin
            for (int i = 0; i < 256; i++) begin
                if (which == 1 && spec_has[i]) ref_mem[i] = spec_val[i];
                spec_has[i] = 1'b0;
            end
            in_tx = 1'b0;
        end
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w0, r0;
        for (int i = 0; i < 256; i++) begin
            ref_mem[i] = init_val(i);
            spec_has[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check_eq("R1 ready", {31'd0, ready}, 32'd1);
        check_eq("R1 tx_active", {31'd0, tx_active}, 32'd0);
        check_eq("R1 ovf_err", {31'd0, ovf_err}, 32'd0);
        check_eq("R1 mem_req", {31'd0, mem_req}, 32'd0);
        check_eq("R1 resp_valid", {31'd0, resp_valid}, 32'd0);

        // R2 R4 R5: plain traffic in set 0
        load("R2 miss load 0x10", 8'h10);
        store("R2 store 0x14", 8'h14, 16'hAAAA);
        load("R2 hit load 0x10", 8'h10);
        w0 = wr_cnt;
        store("R4 store 0x18", 8'h18, 16'hBBBB);
        check_eq("R4 lru victim writes", wr_cnt - w0, 1);
        check_eq("R5 dirty wb addr", {24'd0, last_wr_addr}, 32'h14);
        check_eq("R5 dirty wb data", {16'd0, last_wr_data}, 32'hAAAA);
        w0 = wr_cnt;
        load("R2 reload 0x14", 8'h14);
        check_eq("R5 clean victim silent", wr_cnt - w0, 0);

        // R12 R3 R9: dirty line touched by a transaction, then abort
        store("R2 store 0x21", 8'h21, 16'h1111);
        ctl(0);
        check_eq("R3 tx_active", {31'd0, tx_active}, 32'd1);
        w0 = wr_cnt;
        store("R12 tx store 0x21", 8'h21, 16'h2222);
        check_eq("R12 clean writes", wr_cnt - w0, 1);
        check_eq("R12 clean data", {16'd0, last_wr_data}, 32'h1111);
        load("R3 tx load 0x21", 8'h21);
        ctl(2);
        load("R9 post-abort 0x21", 8'h21);

        // R6 R7 R10 R11: spill, swap back, commit
        ctl(0);
        w0 = wr_cnt;
        store("R6 st 0x02", 8'h02, 16'hB002);
        store("R6 st 0x06", 8'h06, 16'hB006);
        store("R6 st 0x0A", 8'h0A, 16'hB00A);
        check_eq("R6 spill no write", wr_cnt - w0, 0);
        r0 = rd_cnt;
        load("R7 swap load 0x02", 8'h02);
        check_eq("R7 no mem read", rd_cnt - r0, 0);
        ext_intv = 1'b1;
        nack_seen = 1'b0;
        w0 = wr_cnt;
        ctl(1);
        ext_intv = 1'b0;
        check_eq("R10 commit writes", wr_cnt - w0, 1);
        check_eq("R10 commit addr", {24'd0, last_wr_addr}, 32'h06);
        check_eq("R10 commit data", {16'd0, last_wr_data}, 32'hB006);
        check_eq("R11 nack seen", {31'd0, nack_seen}, 32'd1);
        check_eq("R10 tx closed", {31'd0, tx_active}, 32'd0);
        load("R10 load 0x06", 8'h06);
        load("R10 load 0x0A", 8'h0A);

        // R8 R9: table capacity in set 3
        ctl(0);
        w0 = wr_cnt;
        for (int k = 0; k < 10; k++) store("R8 fill", 8'(3 + 4 * k), 16'(16'hC000 + k));
        check_eq("R8 ten lines no error", {31'd0, ovf_err}, 32'd0);
        check_eq("R6 spills no write", wr_cnt - w0, 0);
        store("R8 eleventh", 8'(3 + 40), 16'hC00A);
        check_eq("R8 error raised", {31'd0, ovf_err}, 32'd1);
        ctl(2);
        check_eq("R9 error cleared", {31'd0, ovf_err}, 32'd0);
        check_eq("R9 tx closed", {31'd0, tx_active}, 32'd0);
        load("R9 load 0x03", 8'h03);
        load("R9 load 0x27", 8'h27);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule